// File: doc/BRIEF.md
# Tiled Depth-Stencil Pixel Access Unit

This unit serves single-pixel depth and stencil accesses against a depth surface held in word-addressed memory. Each request names an operation (read or write), a format (16-bit depth, 24-bit depth packed with stencil, or 8-bit stencil packed with depth), a pixel coordinate, the origin of the drawable inside the surface, and for writes the new value. The origin is added to the coordinate first. The sum is then turned into a byte address, either through a bit-interleaved tile swizzle or through a plain row-major layout.

A 16-bit depth access is one halfword transaction on the memory port. The 24-bit depth field and the 8-bit stencil field share one 32-bit word, so a write to either field reads that word, replaces its own field and writes the word back. The neighbouring field is not changed. The unit handles one request at a time. It holds its request port not-ready until the last memory transaction of the current request has completed, so no other access can fall between the two halves of a read-modify-write. Read results come back on a one-cycle response strobe.

Top module: `zs_access_unit`

## Requirements
- R1: The pixel coordinate used for addressing is (req_x + org_x, req_y + org_y), taken modulo the coordinate width, so splitting the same position differently between request and origin reaches the same word.
- R2: With linear_en high, the byte address is 4*(x + y*pitch) for 24-bit depth and stencil, and 2*(x + y*pitch) for 16-bit depth. mem_addr carries the byte address divided by 4.
- R3: With linear_en low and a 32-bit format, let ba = (y/16)*(pitch/16) + x/16. The byte address has bits 1:0 = 0, 4:2 = x[2:0], 6:5 = y[1:0], 7 = x[4]^y[2], 9:8 = ba[1:0], 10 = y[3], 11 = x[3]^y[4], and bits 12 and up = ba/4.
- R4: With linear_en low and 16-bit depth, let ba = (y/16)*(pitch/32) + x/32. The byte address has bit 0 = 0, 3:1 = x[2:0], 6:4 = y[2:0], 7 = x[3], 9:8 = ba[1:0], 10 = y[3], 11 = x[4]^y[4], and bits 12 and up = ba/4.
- R5: Format code 2'b01 is 24-bit depth. A write reads the word and then writes it back with bits 31:24 kept and bits 23:0 set to req_wdata[23:0], using byte enables 4'b1111. A read returns bits 23:0 of the word on rsp_data.
- R6: Format code 2'b10 is stencil. A write reads the word and then writes it back with bits 23:0 kept and bits 31:24 set to req_wdata[7:0]. A read returns bits 31:24 of the word, zero-extended, on rsp_data.
- R7: Format code 2'b00 is 16-bit depth. It makes a single memory transaction with byte enables 4'b0011 when byte address bit 1 is 0 and 4'b1100 when it is 1. The write data carries the value in both halves. A read returns the selected halfword, zero-extended.
- R8: req_ready is low from the accepting edge until the final memory transaction of that request completes. While mem_valid is high and mem_ready is low, mem_addr, mem_we and mem_be hold steady. No access interleaves with a pending read-modify-write.
- R9: After reset, req_ready is 1 while mem_valid and rsp_valid are 0.
- R10: rsp_valid is a single-cycle pulse, given only for reads, in the cycle after mem_rvalid. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and accepting a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fmt | input | 2 | 00 = 16-bit depth, 01 = 24-bit depth, 10 = stencil |
| req_x | input | CW | Pixel x relative to the drawable |
| req_y | input | CW | Pixel y relative to the drawable |
| org_x | input | CW | Drawable x origin on the surface |
| org_y | input | CW | Drawable y origin on the surface |
| req_wdata | input | 24 | Value to write (low bits used for narrower formats) |
| pitch | input | PW | Surface pitch in pixels, a multiple of 32 |
| linear_en | input | 1 | 1 = row-major layout, 0 = tiled swizzle |
| rsp_valid | output | 1 | Read result strobe |
| rsp_data | output | 24 | Read result, zero-extended |
| mem_valid | output | 1 | Memory transaction request |
| mem_ready | input | 1 | Memory accepts the transaction |
| mem_we | output | 1 | 1 = write transaction |
| mem_addr | output | CW+PW+1 | 32-bit word address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Read data word |

## Verification
The case that needs the most care is a read-modify-write whose write-back is stalled at the memory port while a second request is already waiting at the request port. The bench stalls mem_ready during a stencil write to a pixel and, in the same cycles, holds a 24-bit depth write to that same pixel valid. It checks that req_ready stays low and that the stalled transaction holds its address. Once the stall is released, the final word must contain the stencil byte and the depth value together, which shows the two updates ran one after the other.

// File: rtl/zs_pkg.sv
package zs_pkg;

  typedef enum logic [1:0] {
    ZFMT_D16  = 2'b00,
    ZFMT_D24  = 2'b01,
    ZFMT_STEN = 2'b10,
    ZFMT_RSVD = 2'b11
  } zfmt_e;

  typedef enum logic [1:0] {
    ZST_IDLE    = 2'd0,
    ZST_RD_REQ  = 2'd1,
    ZST_RD_WAIT = 2'd2,
    ZST_WR_REQ  = 2'd3
  } zst_e;

  localparam int unsigned ZWORD_W  = 32;
  localparam int unsigned ZDATA_W  = 24;
  localparam int unsigned ZBE_W    = ZWORD_W / 8;

endpackage

// File: rtl/zs_addr_xlate.sv
// Coordinate offset plus tiled/linear address translation.
// Output is a halfword address (byte address bit 0 is always zero).
module zs_addr_xlate
  import zs_pkg::*;
#(
  parameter int unsigned CW  = 12,
  parameter int unsigned PW  = 12,
  localparam int unsigned BAW = CW + PW + 3,
  localparam int unsigned HW  = BAW - 1
) (
  input  zfmt_e          fmt,
  input  logic [CW-1:0]  rel_x,
  input  logic [CW-1:0]  rel_y,
  input  logic [CW-1:0]  org_x,
  input  logic [CW-1:0]  org_y,
  input  logic [PW-1:0]  pitch,
  input  logic           linear_en,
  output logic [HW-1:0]  hw_addr
);

  logic [CW-1:0] px, py;
  logic [HW-1:0] xw, yw, pw;
  logic [HW-1:0] lin_elem;
  logic [HW-1:0] ba_wide, ba_half;
  logic [HW-1:0] t_wide, t_half;
  logic          is_half;

  always_comb begin
    px = rel_x + org_x;
    py = rel_y + org_y;
    xw = HW'(px);
    yw = HW'(py);
    pw = HW'(pitch);
    is_half = (fmt == ZFMT_D16);

    lin_elem = xw + yw * pw;

    // block indices: 16x16 pixel blocks for words, 32x16 for halfwords
    ba_wide = (yw >> 4) * (pw >> 4) + (xw >> 4);
    ba_half = (yw >> 4) * (pw >> 5) + (xw >> 5);

    // halfword units: byte address bits [11:1] below, block high part at 11
    t_wide = ((ba_wide >> 2) << 11)
           | HW'({px[3] ^ py[4], py[3], ba_wide[1:0], px[4] ^ py[2],
                  py[1:0], px[2:0], 1'b0});
    t_half = ((ba_half >> 2) << 11)
           | HW'({px[4] ^ py[4], py[3], ba_half[1:0], px[3],
                  py[2:0], px[2:0]});

    if (linear_en) begin
      hw_addr = is_half ? lin_elem : (lin_elem << 1);
    end else begin
      hw_addr = is_half ? t_half : t_wide;
    end
  end

endmodule

// File: rtl/zs_field_merge.sv
// Packed-field merge for write-back and field extraction for reads.
module zs_field_merge
  import zs_pkg::*;
(
  input  zfmt_e                fmt,
  input  logic                 half_sel,
  input  logic [ZDATA_W-1:0]   new_val,
  input  logic [ZWORD_W-1:0]   old_word,
  output logic [ZWORD_W-1:0]   merged,
  output logic [ZDATA_W-1:0]   extracted
);

  always_comb begin
    unique case (fmt)
      ZFMT_STEN: begin
        merged    = {new_val[7:0], old_word[23:0]};
        extracted = {16'h0000, old_word[31:24]};
      end
      ZFMT_D16: begin
        merged    = {new_val[15:0], new_val[15:0]};
        extracted = {8'h00, (half_sel ? old_word[31:16] : old_word[15:0])};
      end
      default: begin
        merged    = {old_word[31:24], new_val};
        extracted = old_word[23:0];
      end
    endcase
  end

endmodule

// File: rtl/zs_access_ctrl.sv
// Sequencer: one request in flight, read / read-modify-write / direct write.
module zs_access_ctrl
  import zs_pkg::*;
#(
  parameter int unsigned AW = 25
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  zfmt_e               req_fmt,
  input  logic [ZDATA_W-1:0]  req_wdata,
  input  logic [AW-1:0]       acc_word,
  input  logic                acc_half,
  output zfmt_e               cur_fmt,
  output logic                cur_half,
  output logic [ZDATA_W-1:0]  cur_wdata,
  input  logic [ZWORD_W-1:0]  merged,
  input  logic [ZDATA_W-1:0]  extracted,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [ZBE_W-1:0]    mem_be,
  output logic [ZWORD_W-1:0]  mem_wdata,
  input  logic                mem_rvalid,
  output logic                rsp_valid,
  output logic [ZDATA_W-1:0]  rsp_data
);

  zst_e                st_q, st_d;
  logic                lat_en;
  logic                wb_en;
  logic [ZWORD_W-1:0]  wb_d, wb_q;
  logic                rsp_v_d;
  logic                rsp_en;
  logic [AW-1:0]       addr_q;
  logic                half_q;
  logic                write_q;
  zfmt_e               fmt_q;
  logic [ZDATA_W-1:0]  wdata_q;
  logic [ZDATA_W-1:0]  rsp_q;
  logic                rsp_v_q;

  // next-state
  always_comb begin
    st_d    = st_q;
    lat_en  = 1'b0;
    wb_en   = 1'b0;
    wb_d    = merged;
    rsp_v_d = 1'b0;
    rsp_en  = 1'b0;
    unique case (st_q)
      ZST_IDLE: begin
        if (req_valid) begin
          lat_en = 1'b1;
          if (req_write && (req_fmt == ZFMT_D16)) begin
            wb_en = 1'b1;
            wb_d  = {req_wdata[15:0], req_wdata[15:0]};
            st_d  = ZST_WR_REQ;
          end else begin
            st_d  = ZST_RD_REQ;
          end
        end
      end
      ZST_RD_REQ: begin
        if (mem_ready) st_d = ZST_RD_WAIT;
      end
      ZST_RD_WAIT: begin
        if (mem_rvalid) begin
          if (write_q) begin
            wb_en = 1'b1;
            wb_d  = merged;
            st_d  = ZST_WR_REQ;
          end else begin
            rsp_v_d = 1'b1;
            rsp_en  = 1'b1;
            st_d    = ZST_IDLE;
          end
        end
      end
      ZST_WR_REQ: begin
        if (mem_ready) st_d = ZST_IDLE;
      end
      default: st_d = ZST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ZST_IDLE;
      rsp_v_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      rsp_v_q <= rsp_v_d;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (lat_en) begin
      addr_q  <= acc_word;
      half_q  <= acc_half;
      write_q <= req_write;
      fmt_q   <= req_fmt;
      wdata_q <= req_wdata;
    end
    if (wb_en) begin
      wb_q <= wb_d;
    end
    if (rsp_en) begin
      rsp_q <= extracted;
    end
  end

  assign req_ready = (st_q == ZST_IDLE);
  assign mem_valid = (st_q == ZST_RD_REQ) || (st_q == ZST_WR_REQ);
  assign mem_we    = (st_q == ZST_WR_REQ);
  assign mem_addr  = addr_q;
  assign mem_be    = (fmt_q == ZFMT_D16) ? (half_q ? 4'b1100 : 4'b0011) : 4'b1111;
  assign mem_wdata = wb_q;
  assign rsp_valid = rsp_v_q;
  assign rsp_data  = rsp_q;
  assign cur_fmt   = fmt_q;
  assign cur_half  = half_q;
  assign cur_wdata = wdata_q;

endmodule

// File: rtl/zs_access_unit.sv
module zs_access_unit
  import zs_pkg::*;
#(
  parameter int unsigned CW = 12,
  parameter int unsigned PW = 12,
  localparam int unsigned BAW = CW + PW + 3,
  localparam int unsigned HW  = BAW - 1,
  localparam int unsigned AW  = BAW - 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [1:0]          req_fmt,
  input  logic [CW-1:0]       req_x,
  input  logic [CW-1:0]       req_y,
  input  logic [CW-1:0]       org_x,
  input  logic [CW-1:0]       org_y,
  input  logic [23:0]         req_wdata,
  input  logic [PW-1:0]       pitch,
  input  logic                linear_en,
  output logic                rsp_valid,
  output logic [23:0]         rsp_data,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [3:0]          mem_be,
  output logic [31:0]         mem_wdata,
  input  logic                mem_rvalid,
  input  logic [31:0]         mem_rdata
);

  logic [1:0]          rst_sync;
  logic                rst_int_n;
  zfmt_e               fmt_in;
  logic [HW-1:0]       hw_addr;
  zfmt_e               cur_fmt;
  logic                cur_half;
  logic [ZDATA_W-1:0]  cur_wdata;
  logic [ZWORD_W-1:0]  merged;
  logic [ZDATA_W-1:0]  extracted;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign fmt_in = zfmt_e'(req_fmt);

  zs_addr_xlate #(.CW(CW), .PW(PW)) u_xlate (
    .fmt       (fmt_in),
    .rel_x     (req_x),
    .rel_y     (req_y),
    .org_x     (org_x),
    .org_y     (org_y),
    .pitch     (pitch),
    .linear_en (linear_en),
    .hw_addr   (hw_addr)
  );

  zs_field_merge u_merge (
    .fmt       (cur_fmt),
    .half_sel  (cur_half),
    .new_val   (cur_wdata),
    .old_word  (mem_rdata),
    .merged    (merged),
    .extracted (extracted)
  );

  zs_access_ctrl #(.AW(AW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_fmt    (fmt_in),
    .req_wdata  (req_wdata),
    .acc_word   (hw_addr[HW-1:1]),
    .acc_half   (hw_addr[0]),
    .cur_fmt    (cur_fmt),
    .cur_half   (cur_half),
    .cur_wdata  (cur_wdata),
    .merged     (merged),
    .extracted  (extracted),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .mem_wdata  (mem_wdata),
    .mem_rvalid (mem_rvalid),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data)
  );

endmodule

// File: rtl/zs_access_chk.sv
module zs_access_chk #(
  parameter int unsigned AW = 25
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_be,
  input logic          mem_rvalid,
  input logic          rsp_valid
);

  logic rd_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_seen <= 1'b0;
    else if (mem_valid && mem_ready) rd_seen <= !mem_we;
  end

  // R5
  rmw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && (mem_be == 4'hF)) |-> rd_seen);

  // R7
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ((mem_be == 4'b0011) || (mem_be == 4'b1100) || (mem_be == 4'b1111)));

  // R8
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_be)));

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10
  rsp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_rvalid));

endmodule

bind zs_access_unit zs_access_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_be     (mem_be),
  .mem_rvalid (mem_rvalid),
  .rsp_valid  (rsp_valid)
);

// File: tb/zs_access_unit_bench.sv
module zs_access_unit_bench;

  localparam int CW = 12;
  localparam int PW = 12;
  localparam int AW = CW + PW + 1;

  typedef struct packed {
    logic        wr;
    logic [1:0]  fmt;
    logic [11:0] x;
    logic [11:0] y;
    logic [23:0] d;
    logic [11:0] ox;
    logic [11:0] oy;
    logic        lin;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VT [NV] = '{
    '{1'b1, 2'd1, 12'd5,  12'd3,  24'hABCDEF, 12'd0, 12'd0, 1'b0},
    '{1'b1, 2'd2, 12'd5,  12'd3,  24'h00005A, 12'd0, 12'd0, 1'b0},
    '{1'b0, 2'd1, 12'd5,  12'd3,  24'h0,      12'd0, 12'd0, 1'b0},
    '{1'b0, 2'd2, 12'd5,  12'd3,  24'h0,      12'd0, 12'd0, 1'b0},
    '{1'b1, 2'd1, 12'd17, 12'd20, 24'h123456, 12'd4, 12'd6, 1'b0},
    '{1'b0, 2'd1, 12'd21, 12'd26, 24'h0,      12'd0, 12'd0, 1'b0},
    '{1'b1, 2'd0, 12'd8,  12'd5,  24'h001234, 12'd0, 12'd0, 1'b0},
    '{1'b1, 2'd0, 12'd9,  12'd5,  24'h005678, 12'd0, 12'd0, 1'b0},
    '{1'b0, 2'd0, 12'd8,  12'd5,  24'h0,      12'd0, 12'd0, 1'b0},
    '{1'b0, 2'd0, 12'd9,  12'd5,  24'h0,      12'd0, 12'd0, 1'b0},
    '{1'b1, 2'd2, 12'd30, 12'd2,  24'h0000C3, 12'd1, 12'd1, 1'b1},
    '{1'b0, 2'd2, 12'd31, 12'd3,  24'h0,      12'd0, 12'd0, 1'b1},
    '{1'b1, 2'd0, 12'd33, 12'd7,  24'h00BEEF, 12'd0, 12'd0, 1'b1},
    '{1'b0, 2'd0, 12'd33, 12'd7,  24'h0,      12'd0, 12'd0, 1'b1},
    '{1'b1, 2'd1, 12'd47, 12'd47, 24'h0F0F0F, 12'd0, 12'd0, 1'b0},
    '{1'b0, 2'd1, 12'd47, 12'd47, 24'h0,      12'd0, 12'd0, 1'b0}
  };

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic          req_write;
  logic [1:0]    req_fmt;
  logic [CW-1:0] req_x, req_y, org_x, org_y;
  logic [23:0]   req_wdata;
  logic [PW-1:0] pitch;
  logic          linear_en;
  logic          rsp_valid;
  logic [23:0]   rsp_data;
  logic          mem_valid;
  logic          mem_ready = 1'b0;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_be;
  logic [31:0]   mem_wdata;
  logic          mem_rvalid = 1'b0;
  logic [31:0]   mem_rdata = 32'h0;

  zs_access_unit #(.CW(CW), .PW(PW)) u_zs_access_unit (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_fmt(req_fmt), .req_x(req_x), .req_y(req_y),
    .org_x(org_x), .org_y(org_y), .req_wdata(req_wdata),
    .pitch(pitch), .linear_en(linear_en),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int tot = 0;
  int bad = 0;
  bit done = 0;
  bit stall_force = 0;
  int cyc = 0;

  logic [31:0] mem     [logic [AW-1:0]];
  logic [31:0] exp_mem [logic [AW-1:0]];
  int          acc_n = 0;
  logic [AW-1:0] acc_addr [4];
  logic          acc_we   [4];
  logic [3:0]    acc_be   [4];

  // memory responder: one-cycle read latency, periodic stalls
  always @(posedge clk) begin
    logic [31:0] w;
    int k;
    cyc = cyc + 1;
    mem_ready  <= stall_force ? 1'b0 : ((cyc % 3) != 1);
    mem_rvalid <= 1'b0;
    if (mem_valid && mem_ready) begin
      k = (acc_n > 3) ? 3 : acc_n;
      acc_addr[k] = mem_addr;
      acc_we[k]   = mem_we;
      acc_be[k]   = mem_be;
      acc_n = acc_n + 1;
      w = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) w[8*b +: 8] = mem_wdata[8*b +: 8];
        mem[mem_addr] = w;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= w;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tot++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // address model written from R2/R3/R4
  function automatic longint ref_byte(input int fmt, input int x, input int y,
                                      input int p, input bit lin);
    longint ba, a;
    if (lin) return longint'(x + y * p) * ((fmt == 0) ? 2 : 4);
    if (fmt == 0) begin
      ba = (y / 16) * (p / 32) + x / 32;
      a = (x % 8) * 2 + (y % 8) * 16 + ((x / 8) % 2) * 128 + (ba % 4) * 256
        + ((y / 8) % 2) * 1024 + ((((x / 16) % 2) ^ ((y / 16) % 2)) * 2048)
        + (ba / 4) * 4096;
    end else begin
      ba = (y / 16) * (p / 16) + x / 16;
      a = (x % 8) * 4 + (y % 4) * 32 + ((((x / 16) % 2) ^ ((y / 4) % 2)) * 128)
        + (ba % 4) * 256 + ((y / 8) % 2) * 1024
        + ((((x / 8) % 2) ^ ((y / 16) % 2)) * 2048) + (ba / 4) * 4096;
    end
    return a;
  endfunction

  task automatic issue(input bit wr, input logic [1:0] fmt, input int x, input int y,
                       input logic [23:0] d, input int ox, input int oy, input bit lin);
    @(negedge clk);
    acc_n = 0;
    req_write = wr; req_fmt = fmt; req_x = CW'(x); req_y = CW'(y);
    org_x = CW'(ox); org_y = CW'(oy); req_wdata = d; linear_en = lin;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
  endtask

  // full request with checks against the shadow memory
  task automatic run_vec(input bit wr, input logic [1:0] fmt, input int x, input int y,
                         input logic [23:0] d, input int ox, input int oy, input bit lin);
    longint ba;
    logic [AW-1:0] wa;
    logic [31:0] ew;
    logic [23:0] ev;
    string tag;
    int px, py;
    px = (x + ox) % 4096;
    py = (y + oy) % 4096;
    ba = ref_byte(fmt, px, py, int'(pitch), lin);
    wa = AW'(ba >> 2);
    tag = lin ? "R2" : ((fmt == 2'd0) ? "R4" : "R3");
    if ((ox != 0) || (oy != 0)) tag = {"R1/", tag};
    ew = exp_mem.exists(wa) ? exp_mem[wa] : 32'h0;
    issue(wr, fmt, x, y, d, ox, oy, lin);
    chk(acc_addr[0] == wa, tag, "word address", longint'(acc_addr[0]), longint'(wa));
    if (wr) begin
      chk(rsp_valid == 1'b0, "R10", "no response on write", longint'(rsp_valid), 0);
      if (fmt == 2'd0) begin
        if (ba[1]) ew[31:16] = d[15:0]; else ew[15:0] = d[15:0];
        chk(acc_n == 1 && acc_we[0] && acc_be[0] == (ba[1] ? 4'b1100 : 4'b0011),
            "R7", "single halfword write be", longint'(acc_be[0]),
            longint'(ba[1] ? 4'b1100 : 4'b0011));
      end else begin
        if (fmt == 2'd2) ew[31:24] = d[7:0]; else ew[23:0] = d;
        chk(acc_n == 2 && !acc_we[0] && acc_we[1] && acc_be[1] == 4'hF,
            (fmt == 2'd2) ? "R6" : "R5", "read then write count", acc_n, 2);
      end
      exp_mem[wa] = ew;
      chk((mem.exists(wa) ? mem[wa] : 32'h0) == ew, (fmt == 2'd2) ? "R6" : "R5",
          "stored word", longint'(mem.exists(wa) ? mem[wa] : 32'h0), longint'(ew));
    end else begin
      if (fmt == 2'd0)      ev = {8'h00, (ba[1] ? ew[31:16] : ew[15:0])};
      else if (fmt == 2'd2) ev = {16'h0000, ew[31:24]};
      else                  ev = ew[23:0];
      chk(rsp_valid == 1'b1, "R10", "read response strobe", longint'(rsp_valid), 1);
      chk(rsp_data == ev, (fmt == 2'd0) ? "R7" : ((fmt == 2'd2) ? "R6" : "R5"),
          "read data", longint'(rsp_data), longint'(ev));
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R10", "response is one cycle", longint'(rsp_valid), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tot++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", tot, bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_fmt = 2'd0;
    req_x = '0; req_y = '0; org_x = '0; org_y = '0; req_wdata = '0;
    pitch = PW'(64); linear_en = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(req_ready == 1'b1, "R9", "req_ready after reset", longint'(req_ready), 1);
    chk(mem_valid == 1'b0, "R9", "mem_valid after reset", longint'(mem_valid), 0);
    chk(rsp_valid == 1'b0, "R9", "rsp_valid after reset", longint'(rsp_valid), 0);

    for (int i = 0; i < NV; i++)
      run_vec(VT[i].wr, VT[i].fmt, int'(VT[i].x), int'(VT[i].y), VT[i].d,
              int'(VT[i].ox), int'(VT[i].oy), VT[i].lin);

    // R3 / R4 with a pitch that is not a power of two
    pitch = PW'(96);
    run_vec(1'b1, 2'd0, 70, 40, 24'h00A5A5, 0, 0, 1'b0);
    run_vec(1'b0, 2'd0, 70, 40, 24'h0, 0, 0, 1'b0);
    run_vec(1'b1, 2'd1, 50, 20, 24'h777777, 0, 0, 1'b0);
    run_vec(1'b0, 2'd1, 50, 20, 24'h0, 0, 0, 1'b0);
    // R1 origin wrap
    run_vec(1'b1, 2'd1, 4090, 10, 24'h010203, 20, 0, 1'b0);
    run_vec(1'b0, 2'd1, 14, 10, 24'h0, 0, 0, 1'b0);
    pitch = PW'(64);

    // R8: stalled read-modify-write with a second request waiting
    stall_force = 1'b1;
    repeat (2) @(negedge clk);
    a0 = AW'(ref_byte(2, 2, 2, 64, 1'b0) >> 2);
    acc_n = 0;
    req_write = 1'b1; req_fmt = 2'd2; req_x = CW'(2); req_y = CW'(2);
    org_x = '0; org_y = '0; req_wdata = 24'h000033; linear_en = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_fmt = 2'd1; req_wdata = 24'h445566;
    for (int k = 0; k < 5; k++) begin
      chk(!req_ready && mem_valid && !mem_we && mem_addr == a0, "R8",
          "held while stalled", longint'(mem_addr), longint'(a0));
      @(negedge clk);
    end
    stall_force = 1'b0;
    while (!req_ready) @(negedge clk);
    chk(acc_n == 2, "R8", "first request alone before second", acc_n, 2);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    chk(acc_n == 4, "R8", "second request accesses", acc_n, 4);
    chk(mem[a0] == 32'h33445566, "R8", "no interleave in packed word",
        longint'(mem[a0]), longint'(32'h33445566));

    done = 1;
    $display("test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end

endmodule